// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block picks the two source operands that the decode stage of a five-stage pipeline hands to execute. Each operand is named by a 4-bit register identifier. The block compares that identifier against the destinations of five results that are still in flight and have not yet reached the register file:

- the ALU result now leaving execute;
- the loaded word and the ALU result held in the memory stage;
- the loaded word and the ALU result held in the write-back stage.

When one or more of these destinations match, the youngest producer's value replaces the register-file read. When none match, the register-file read passes through unchanged.

The block is purely combinational and holds no state. Stall and bubble generation, including the one-cycle hold for a load whose result is needed at once, belong to the pipeline control. The register file also lies outside this block. Once the control has inserted that one-cycle hold, the memory-stage loaded word is simply one more candidate here. An identifier of all ones means "no register" and never takes part in a match.

Top module: `fwd_unit`

## Requirements
- R1: When no in-flight destination equals a source identifier, that operand equals its register-file read value.
- R2: A match on the execute-stage ALU destination selects the execute ALU result, whatever the other four sources hold.
- R3: A match on the memory-stage load destination selects the memory loaded word over the memory ALU result and both write-back values.
- R4: A match on the memory-stage ALU destination selects the memory ALU result over both write-back values.
- R5: A match on the write-back load destination selects the write-back loaded word over the write-back ALU result.
- R6: A match on the write-back ALU destination alone selects the write-back ALU result in place of the register-file read.
- R7: A source identifier of 4'hF (no register) always yields the register-file read value, even when destinations are also 4'hF.
- R8: The two operands are resolved independently. One source may feed both, or each may come from a different source.
- R9: The operands follow their inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_id | input | 4 | Register identifier of operand A |
| src_b_id | input | 4 | Register identifier of operand B |
| rf_a_data | input | 32 | Register-file read for operand A |
| rf_b_data | input | 32 | Register-file read for operand B |
| ex_alu_dst | input | 4 | Destination of the execute ALU result |
| ex_alu_val | input | 32 | Execute ALU result |
| mem_ld_dst | input | 4 | Destination of the memory-stage loaded word |
| mem_ld_val | input | 32 | Memory-stage loaded word |
| mem_alu_dst | input | 4 | Destination of the memory-stage ALU result |
| mem_alu_val | input | 32 | Memory-stage ALU result |
| wb_ld_dst | input | 4 | Destination of the write-back loaded word |
| wb_ld_val | input | 32 | Write-back loaded word |
| wb_alu_dst | input | 4 | Destination of the write-back ALU result |
| wb_alu_val | input | 32 | Write-back ALU result |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The block holds no state, so a fault shows up as a wrong operand value in the same cycle as the input pattern that exposes it. A broken comparator or "no register" guard shows up as a stale register-file value, or as a bypass value where none should appear. A reversed priority chain shows up only when two or more stages name the same register. For that reason the stimulus stacks matches across stages and then removes the youngest producer one at a time. Every candidate carries a distinct data word, so each wrong selection produces a visible value difference.

// File: rtl/fwd_pkg.sv
// Package fwd_pkg
// Shared widths and source ordering for the decode operand bypass selector.
// Assumes the candidate index doubles as priority: index 0 is the youngest.
package fwd_pkg;
    localparam int unsigned FWD_ID_W    = 4;
    localparam int unsigned FWD_DATA_W  = 32;
    localparam int unsigned FWD_NUM_SRC = 5;

    // Candidate slots, youngest producer first; the order is the priority.
    typedef enum int unsigned {
        SRC_EX_ALU  = 0,
        SRC_MEM_LD  = 1,
        SRC_MEM_ALU = 2,
        SRC_WB_LD   = 3,
        SRC_WB_ALU  = 4
    } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// Module fwd_match
// Compares one source identifier against every candidate destination.
// Assumes the all-ones identifier means "no register" and must never hit.
module fwd_match #(
    parameter int unsigned ID_W    = 4,
    parameter int unsigned NUM_SRC = 5
) (
    input  logic [ID_W-1:0]              src_id,
    input  logic [NUM_SRC-1:0][ID_W-1:0] cand_dst,
    output logic [NUM_SRC-1:0]           hit
);
    localparam logic [ID_W-1:0] NO_REG = '1;

    logic src_valid;

    // Purpose: a "no register" source disables every comparison.
    always_comb src_valid = (src_id != NO_REG);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        // Purpose: one equality comparator per in-flight destination.
        always_comb hit[g] = src_valid && (cand_dst[g] == src_id);
    end
endmodule

// File: rtl/fwd_prio.sv
// Module fwd_prio
// Fixed-priority picker: the lowest set hit index wins.
// Assumes index 0 is the youngest producer in the pipeline.
module fwd_prio #(
    parameter int unsigned NUM_SRC = 5,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] hit,
    output logic [NUM_SRC-1:0] grant,
    output logic [SEL_W-1:0]   sel,
    output logic               any_hit
);
    // Purpose: scan from the oldest to the youngest so the youngest hit ends up selected.
    always_comb begin
        grant   = '0;
        sel     = '0;
        any_hit = |hit;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                sel      = SEL_W'(i);
            end
        end
    end

    // Purpose: the grant is one-hot, grants only a hit, and exists whenever any hit does.
    always_comb begin
        if (!$isunknown(hit)) begin
            // R8
            grant_onehot_chk: assert ($onehot0(grant))
                else $error("grant not one-hot: %b", grant);
            // R2
            grant_in_hit_chk: assert ((grant & ~hit) == '0)
                else $error("grant %b outside hit %b", grant, hit);
            // R6
            grant_present_chk: assert ((hit == '0) || (grant != '0))
                else $error("hit %b without grant", hit);
        end
    end
endmodule

// File: rtl/fwd_operand.sv
// Module fwd_operand
// Resolves one decode operand from the register file or the bypass candidates.
// Assumes candidates are ordered youngest first and the all-ones identifier means none.
module fwd_operand #(
    parameter int unsigned ID_W    = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 5
) (
    input  logic [ID_W-1:0]                src_id,
    input  logic [DATA_W-1:0]              rf_val,
    input  logic [NUM_SRC-1:0][ID_W-1:0]   cand_dst,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] cand_val,
    output logic [DATA_W-1:0]              opnd
);
    localparam int unsigned     SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ID_W-1:0] NO_REG = '1;

    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] grant;
    logic [SEL_W-1:0]   sel;
    logic               any_hit;

    fwd_match #(.ID_W(ID_W), .NUM_SRC(NUM_SRC)) u_match (
        .src_id   (src_id),
        .cand_dst (cand_dst),
        .hit      (hit)
    );

    fwd_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .hit     (hit),
        .grant   (grant),
        .sel     (sel),
        .any_hit (any_hit)
    );

    // Purpose: choose the granted candidate, or fall back to the register file.
    always_comb opnd = any_hit ? cand_val[sel] : rf_val;

    // Purpose: check the operand against the port-level selection rules.
    always_comb begin
        if (!$isunknown({src_id, cand_dst, rf_val, cand_val})) begin
            // R1
            rf_default_chk: assert ((hit != '0) || (opnd == rf_val))
                else $error("no hit but operand %h != rf %h", opnd, rf_val);
            // R7
            none_id_chk: assert ((src_id != NO_REG) || (opnd == rf_val))
                else $error("none id forwarded %h", opnd);
            // R2
            newest_wins_chk: assert ((src_id == NO_REG) || (cand_dst[0] != src_id)
                                     || (opnd == cand_val[0]))
                else $error("youngest match lost: %h", opnd);
        end
    end
endmodule

// File: rtl/fwd_unit.sv
// Module fwd_unit
// Top of the decode operand bypass selector: two independent operand resolvers
// sharing five in-flight candidates. Purely combinational, no clock or reset.
// Assumes destinations of instructions that write no register carry 4'hF.
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [FWD_ID_W-1:0]   src_a_id,
    input  logic [FWD_ID_W-1:0]   src_b_id,
    input  logic [FWD_DATA_W-1:0] rf_a_data,
    input  logic [FWD_DATA_W-1:0] rf_b_data,
    input  logic [FWD_ID_W-1:0]   ex_alu_dst,
    input  logic [FWD_DATA_W-1:0] ex_alu_val,
    input  logic [FWD_ID_W-1:0]   mem_ld_dst,
    input  logic [FWD_DATA_W-1:0] mem_ld_val,
    input  logic [FWD_ID_W-1:0]   mem_alu_dst,
    input  logic [FWD_DATA_W-1:0] mem_alu_val,
    input  logic [FWD_ID_W-1:0]   wb_ld_dst,
    input  logic [FWD_DATA_W-1:0] wb_ld_val,
    input  logic [FWD_ID_W-1:0]   wb_alu_dst,
    input  logic [FWD_DATA_W-1:0] wb_alu_val,
    output logic [FWD_DATA_W-1:0] opnd_a,
    output logic [FWD_DATA_W-1:0] opnd_b
);
    localparam int unsigned NUM_OPND = 2;

    logic [FWD_NUM_SRC-1:0][FWD_ID_W-1:0]   cand_dst;
    logic [FWD_NUM_SRC-1:0][FWD_DATA_W-1:0] cand_val;
    logic [NUM_OPND-1:0][FWD_ID_W-1:0]      src_ids;
    logic [NUM_OPND-1:0][FWD_DATA_W-1:0]    rf_vals;
    logic [NUM_OPND-1:0][FWD_DATA_W-1:0]    opnds;

    // Purpose: pack the candidates in priority order, youngest first.
    always_comb begin
        cand_dst[SRC_EX_ALU]  = ex_alu_dst;
        cand_val[SRC_EX_ALU]  = ex_alu_val;
        cand_dst[SRC_MEM_LD]  = mem_ld_dst;
        cand_val[SRC_MEM_LD]  = mem_ld_val;
        cand_dst[SRC_MEM_ALU] = mem_alu_dst;
        cand_val[SRC_MEM_ALU] = mem_alu_val;
        cand_dst[SRC_WB_LD]   = wb_ld_dst;
        cand_val[SRC_WB_LD]   = wb_ld_val;
        cand_dst[SRC_WB_ALU]  = wb_alu_dst;
        cand_val[SRC_WB_ALU]  = wb_alu_val;
    end

    // Purpose: gather per-operand identifiers and register-file reads.
    always_comb begin
        src_ids[0] = src_a_id;
        src_ids[1] = src_b_id;
        rf_vals[0] = rf_a_data;
        rf_vals[1] = rf_b_data;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand #(
            .ID_W    (FWD_ID_W),
            .DATA_W  (FWD_DATA_W),
            .NUM_SRC (FWD_NUM_SRC)
        ) u_opnd (
            .src_id   (src_ids[g]),
            .rf_val   (rf_vals[g]),
            .cand_dst (cand_dst),
            .cand_val (cand_val),
            .opnd     (opnds[g])
        );
    end

    // Purpose: drive the operand outputs.
    always_comb begin
        opnd_a = opnds[0];
        opnd_b = opnds[1];
    end
endmodule

// File: tb/sim_fwd_unit.sv
// Directed bench for fwd_unit: one task per scenario, each checking its own results.
module sim_fwd_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] NONE = 4'hF;
    localparam logic [31:0] RFA = 32'hAAAA_0001, RFB = 32'hBBBB_0002;
    localparam logic [31:0] VEX = 32'h1111_1111, VML = 32'h2222_2222, VMA = 32'h3333_3333;
    localparam logic [31:0] VWL = 32'h4444_4444, VWA = 32'h5555_5555;

    logic clk = 1'b0;
    logic [3:0]  src_a_id, src_b_id, ex_alu_dst, mem_ld_dst, mem_alu_dst, wb_ld_dst, wb_alu_dst;
    logic [31:0] rf_a_data, rf_b_data, ex_alu_val, mem_ld_val, mem_alu_val, wb_ld_val, wb_alu_val;
    logic [31:0] opnd_a, opnd_b;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_unit u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive all destinations at once (a/b sources separately).
    task automatic drive(logic [3:0] sa, logic [3:0] sb, logic [3:0] dex, logic [3:0] dml,
                         logic [3:0] dma, logic [3:0] dwl, logic [3:0] dwa);
        @(negedge clk);
        src_a_id = sa; src_b_id = sb;
        ex_alu_dst = dex; mem_ld_dst = dml; mem_alu_dst = dma;
        wb_ld_dst = dwl; wb_alu_dst = dwa;
        #1;
    endtask

    task automatic t_idle();
        drive(4'd2, 4'd3, NONE, NONE, NONE, NONE, NONE);
        chk("R1 idle A", opnd_a, RFA);
        chk("R1 idle B", opnd_b, RFB);
        drive(4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9);
        chk("R1 other regs A", opnd_a, RFA);
        chk("R1 other regs B", opnd_b, RFB);
    endtask

    task automatic t_single();
        drive(4'd4, NONE, 4'd4, NONE, NONE, NONE, NONE); chk("R2 ex alone", opnd_a, VEX);
        drive(4'd4, NONE, NONE, 4'd4, NONE, NONE, NONE); chk("R3 mem ld alone", opnd_a, VML);
        drive(4'd4, NONE, NONE, NONE, 4'd4, NONE, NONE); chk("R4 mem alu alone", opnd_a, VMA);
        drive(4'd4, NONE, NONE, NONE, NONE, 4'd4, NONE); chk("R5 wb ld alone", opnd_a, VWL);
        drive(NONE, 4'd4, NONE, NONE, NONE, NONE, 4'd4); chk("R6 wb alu alone B", opnd_b, VWA);
        drive(4'd4, 4'd1, NONE, NONE, NONE, NONE, 4'd1); chk("R6 wb alu B", opnd_b, VWA);
        chk("R6 A untouched", opnd_a, RFA);
    endtask

    task automatic t_stacked();
        drive(4'd6, 4'd6, 4'd6, 4'd6, 4'd6, 4'd6, 4'd6);
        chk("R2 all match A", opnd_a, VEX); chk("R2 all match B", opnd_b, VEX);
        drive(4'd6, 4'd6, 4'd0, 4'd6, 4'd6, 4'd6, 4'd6); chk("R3 over older", opnd_a, VML);
        drive(4'd6, 4'd6, 4'd0, 4'd0, 4'd6, 4'd6, 4'd6); chk("R4 over wb", opnd_a, VMA);
        drive(4'd6, 4'd6, 4'd0, 4'd0, 4'd0, 4'd6, 4'd6); chk("R5 wb ld over wb alu", opnd_a, VWL);
        drive(4'd6, 4'd6, 4'd6, NONE, NONE, NONE, 4'd6); chk("R2 ex over wb alu", opnd_b, VEX);
    endtask

    task automatic t_none();
        drive(NONE, NONE, NONE, NONE, NONE, NONE, NONE);
        chk("R7 none A", opnd_a, RFA); chk("R7 none B", opnd_b, RFB);
    endtask

    task automatic t_split();
        drive(4'd1, 4'd2, 4'd1, NONE, 4'd2, NONE, 4'd2);
        chk("R8 A from ex", opnd_a, VEX); chk("R8 B from mem alu", opnd_b, VMA);
        drive(4'd2, 4'd1, 4'd1, NONE, NONE, 4'd2, NONE);
        chk("R8 A from wb ld", opnd_a, VWL); chk("R8 B from ex", opnd_b, VEX);
    endtask

    task automatic t_comb();
        drive(4'd3, 4'd3, 4'd3, NONE, NONE, NONE, NONE);
        chk("R9 before", opnd_a, VEX);
        ex_alu_val = 32'hDEAD_BEEF; rf_b_data = 32'h0BAD_F00D; #1;
        chk("R9 same cycle A", opnd_a, 32'hDEAD_BEEF);
        src_b_id = 4'd9; #1;
        chk("R9 same cycle B", opnd_b, 32'h0BAD_F00D);
        ex_alu_val = VEX; rf_b_data = RFB;
    endtask

    initial begin
        rf_a_data = RFA; rf_b_data = RFB;
        ex_alu_val = VEX; mem_ld_val = VML; mem_alu_val = VMA;
        wb_ld_val = VWL; wb_alu_val = VWA;
        src_a_id = NONE; src_b_id = NONE;
        ex_alu_dst = NONE; mem_ld_dst = NONE; mem_alu_dst = NONE; wb_ld_dst = NONE; wb_alu_dst = NONE;
        t_idle(); t_single(); t_stacked(); t_none(); t_split(); t_comb();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule